// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block works out which interrupt source should be serviced first, using an ordering that software sets. It holds a table of 40 priority slots. Each slot either names a source or is turned off. The slot number sets the priority, so the slot table is an indirection from rank to source. The fixed source numbering plays no part in the order.

The block receives three 40-bit vectors, one bit per source:

- a pending vector;
- an enable vector;
- a class vector. A class bit of 1 marks a source as fast (FIQ) class, and 0 marks it as normal (IRQ) class.

The FIQ winner and the IRQ winner are resolved at the same time. Both are packed into one 32-bit status word. The status word can be read at its bus offset, and it is also driven on a dedicated output. Resolution is a purely combinational find-first over the registered slot table, so the word always reflects the current inputs.

Software programs the slots through a simple register bus with one write strobe. The read data is combinational from the address.

Top module: `pir_resolver`

## Requirements
- R1: After reset every slot reads 0x00000000 and the status word reads 0x003F003F.
- R2: A write to a slot keeps only data bit 31 (the on bit) and bits 5:0 (the source number). Every other bit reads back as zero.
- R3: Slots 0 to 31 sit at byte offsets 0x1C + 4·n. Slots 32 to 39 sit at offsets 0xB0 + 4·(n−32).
- R4: A write to an offset that maps to no register, or to an offset whose low two bits are not zero, changes nothing. A read of such an offset returns 0.
- R5: A slot takes part in resolution only when its on bit is 1 and its source number is below 40.
- R6: Among the slots that take part, the lowest-numbered slot whose source qualifies wins, whatever its source number.
- R7: A source qualifies for the FIQ winner when its class bit is 1, and for the IRQ winner when its class bit is 0. The two winners are resolved independently.
- R8: The status word has this layout: bit 31 is the IRQ found flag, bits 21:16 are the IRQ winner, bit 15 is the FIQ found flag, and bits 5:0 are the FIQ winner. All other bits are 0. The word is read at offset 0x18.
- R9: A class with no winner shows a found flag of 0 and a winner field of 0x3F.
- R10: A source qualifies only while both its pending bit and its enable bit are 1.
- R11: The status word follows the inputs in the same cycle. Writes to offset 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | 40 | Pending bit per source |
| src_en | input | 40 | Enable bit per source |
| src_lvl | input | 40 | Class per source (1 = FIQ, 0 = IRQ) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| win_status | output | 32 | Status word |

## Verification
A corrupted slot entry is visible on the very next read of that slot. It also shows in the status word in the same cycle that its source becomes pending and enabled. A wrong winner therefore appears at once as a wrong ID field, or as a found flag that disagrees with the source inputs. The tests place a low source number in a high slot, mix the two classes, and program invalid or out-of-range slots, so that an encoder ordered by source number or one that ignores the qualifier gives a different word.

// File: rtl/pir_pkg.sv
`timescale 1ns/1ps
package pir_pkg;
    localparam int ID_W        = 6;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int STATUS_OFF  = 'h18;
    localparam int LOW_BASE    = 'h1C;
    localparam int HIGH_BASE   = 'hB0;
    localparam logic [ID_W-1:0] NO_WIN = '1;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } slot_t;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_STATUS,
        REG_SLOT
    } reg_kind_e;
endpackage

// File: rtl/pir_addr_dec.sv
`timescale 1ns/1ps
module pir_addr_dec
    import pir_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    parameter int LOW_BANK  = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam int LOW_LAST  = LOW_BASE + 4 * (LOW_BANK - 1);
    localparam int HIGH_LAST = HIGH_BASE + 4 * (NUM_SLOTS - LOW_BANK - 1);

    int a_i;

    always_comb begin
        a_i      = int'(addr);
        kind     = REG_NONE;
        slot_idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (a_i == STATUS_OFF) begin
                kind = REG_STATUS;
            end else if (a_i >= LOW_BASE && a_i <= LOW_LAST) begin
                kind     = REG_SLOT;
                slot_idx = SLOT_W'((a_i - LOW_BASE) >> 2);
            end else if (a_i >= HIGH_BASE && a_i <= HIGH_LAST) begin
                kind     = REG_SLOT;
                slot_idx = SLOT_W'(LOW_BANK + ((a_i - HIGH_BASE) >> 2));
            end
        end
    end
endmodule

// File: rtl/pir_slot_bank.sv
`timescale 1ns/1ps
module pir_slot_bank
    import pir_pkg::*;
#(
    parameter int NUM_SLOTS = 40,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SLOT_W-1:0]           wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    output slot_t [NUM_SLOTS-1:0]       slots
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[s] <= '0;
            end else if (wr_en && (int'(wr_idx) == s)) begin
                slots[s].vld <= wr_data[DATA_W-1];
                slots[s].id  <= wr_data[ID_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pir_class_pick.sv
`timescale 1ns/1ps
module pir_class_pick
    import pir_pkg::*;
#(
    parameter int NUM_SRC   = 40,
    parameter int NUM_SLOTS = 40,
    parameter bit FIQ_SIDE  = 1'b0
) (
    input  slot_t [NUM_SLOTS-1:0] slots,
    input  logic [NUM_SRC-1:0]    pend,
    input  logic [NUM_SRC-1:0]    en,
    input  logic [NUM_SRC-1:0]    lvl,
    output logic                  hit,
    output logic [ID_W-1:0]       win_id
);
    localparam int PAD_W = 1 << ID_W;

    logic [NUM_SRC-1:0]   ready;
    logic [PAD_W-1:0]     ready_pad;
    logic [NUM_SLOTS-1:0] qual;

    if (FIQ_SIDE) begin : g_fiq
        assign ready = pend & en & lvl;
    end else begin : g_irq
        assign ready = pend & en & ~lvl;
    end

    assign ready_pad = PAD_W'(ready);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_qual
        assign qual[s] = slots[s].vld
                       && (int'(slots[s].id) < NUM_SRC)
                       && ready_pad[slots[s].id];
    end

    // find-first from slot 0: the last hit in a descending scan wins
    always_comb begin
        hit    = 1'b0;
        win_id = NO_WIN;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (qual[s]) begin
                hit    = 1'b1;
                win_id = slots[s].id;
            end
        end
    end
endmodule

// File: rtl/pir_resolver.sv
`timescale 1ns/1ps
module pir_resolver
    import pir_pkg::*;
#(
    parameter int NUM_SRC   = 40,
    parameter int NUM_SLOTS = 40,
    parameter int LOW_BANK  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0]  win_status
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    reg_kind_e              kind;
    logic [SLOT_W-1:0]      slot_idx;
    slot_t [NUM_SLOTS-1:0]  slots;
    logic                   irq_hit, fiq_hit;
    logic [ID_W-1:0]        irq_id, fiq_id;

    pir_addr_dec #(.NUM_SLOTS(NUM_SLOTS), .LOW_BANK(LOW_BANK)) u_dec (
        .addr     (bus_addr),
        .kind     (kind),
        .slot_idx (slot_idx)
    );

    pir_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && (kind == REG_SLOT)),
        .wr_idx  (slot_idx),
        .wr_data (bus_wdata),
        .slots   (slots)
    );

    pir_class_pick #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .FIQ_SIDE(1'b0)) u_irq (
        .slots  (slots),
        .pend   (src_pend),
        .en     (src_en),
        .lvl    (src_lvl),
        .hit    (irq_hit),
        .win_id (irq_id)
    );

    pir_class_pick #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .FIQ_SIDE(1'b1)) u_fiq (
        .slots  (slots),
        .pend   (src_pend),
        .en     (src_en),
        .lvl    (src_lvl),
        .hit    (fiq_hit),
        .win_id (fiq_id)
    );

    assign win_status = {irq_hit, 9'b0, irq_id, fiq_hit, 9'b0, fiq_id};

    always_comb begin
        unique case (kind)
            REG_STATUS: bus_rdata = win_status;
            REG_SLOT:   bus_rdata = {slots[slot_idx].vld, {(DATA_W-1-ID_W){1'b0}},
                                     slots[slot_idx].id};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pir_resolver_chk.sv
`timescale 1ns/1ps
module pir_resolver_chk #(
    parameter int NUM_SRC = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pend,
    input logic [NUM_SRC-1:0] src_en,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [31:0]        win_status
);
    logic [63:0] pend_p, en_p, lvl_p;
    assign pend_p = 64'(src_pend);
    assign en_p   = 64'(src_en);
    assign lvl_p  = 64'(src_lvl);

    // R8
    status_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_status[30:22] == 9'b0 && win_status[14:6] == 9'b0);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_status[31] |-> win_status[21:16] == 6'h3F);

    // R9
    fiq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_status[15] |-> win_status[5:0] == 6'h3F);

    // R7
    irq_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_status[31] |-> (pend_p[win_status[21:16]] && en_p[win_status[21:16]]
                            && !lvl_p[win_status[21:16]]));

    // R7
    fiq_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_status[15] |-> (pend_p[win_status[5:0]] && en_p[win_status[5:0]]
                            && lvl_p[win_status[5:0]]));

    // R5
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_status[31] |-> int'(win_status[21:16]) < NUM_SRC);

    // R2
    slot_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr != 8'h18 |-> bus_rdata[30:6] == 25'b0);

    // R11
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 8'h18 |-> bus_rdata == win_status);
endmodule

bind pir_resolver pir_resolver_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_pend   (src_pend),
    .src_en     (src_en),
    .src_lvl    (src_lvl),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .win_status (win_status)
);

// File: tb/pir_resolver_test.sv
`timescale 1ns/1ps
module pir_resolver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_pend = '0, src_en = '0, src_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, win_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    pir_resolver uut (
        .clk(clk), .rst_n(rst_n),
        .src_pend(src_pend), .src_en(src_en), .src_lvl(src_lvl),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .win_status(win_status)
    );

    task automatic chk_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_wr   = 1'b0;
        bus_addr = a;
        sb.push_back('{a, e, tag});
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk); #1;
        bus_wr    = 1'b0;
    endtask

    task automatic set_src(input logic [39:0] p, input logic [39:0] e, input logic [39:0] l);
        @(posedge clk); #1;
        src_pend = p;
        src_en   = e;
        src_lvl  = l;
    endtask

    // monitor: compare against scoreboard away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, bus_rdata, it.exp);
            end
            if (it.addr == 8'h18) begin
                checks++;
                if (win_status !== it.exp) begin
                    errors++;
                    $display("FAIL %s status port actual=%h expected=%h", it.tag, win_status, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [39:0] B5  = 40'h1 << 5;
    localparam logic [39:0] B6  = 40'h1 << 6;
    localparam logic [39:0] B7  = 40'h1 << 7;
    localparam logic [39:0] B39 = 40'h1 << 39;
    localparam logic [39:0] ALL = '1;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_read(8'h18, 32'h003F003F, "R1 status after reset");
        chk_read(8'h1C, 32'h0, "R1 slot0 after reset");
        chk_read(8'hCC, 32'h0, "R1 slot39 after reset");

        // R2 masking, R3 mapping
        bus_write(8'h1C, 32'hFFFF_FFC5);
        chk_read(8'h1C, 32'h8000_0005, "R2 slot0 masked");
        bus_write(8'h98, 32'h1234_5678);
        chk_read(8'h98, 32'h0000_0038, "R2 slot31 masked");
        bus_write(8'hB4, 32'h8000_0027);
        chk_read(8'hB4, 32'h8000_0027, "R3 slot33 high bank");
        chk_read(8'h20, 32'h0, "R3 slot1 untouched");

        // R4 unmapped and misaligned
        bus_write(8'hA0, 32'hFFFF_FFFF);
        chk_read(8'hA0, 32'h0, "R4 unmapped read");
        bus_write(8'h1D, 32'h0000_0011);
        chk_read(8'h1C, 32'h8000_0005, "R4 misaligned write ignored");
        chk_read(8'h1D, 32'h0, "R4 misaligned read");

        // R11 status write ignored
        bus_write(8'h18, 32'h0);
        chk_read(8'h18, 32'h003F003F, "R11 status write ignored");

        // resolution
        set_src(B39, B39, '0);
        chk_read(8'h18, 32'h8027_003F, "R8 irq winner 39");
        set_src(B39 | B5, B39 | B5, '0);
        chk_read(8'h18, 32'h8005_003F, "R6 slot0 beats slot33");
        set_src(B39 | B5, B39 | B5, B5);
        chk_read(8'h18, 32'h8027_8005, "R7 fiq and irq together");
        set_src(B39 | B5, B39, B5);
        chk_read(8'h18, 32'h8027_003F, "R10 disabled source");
        set_src(B39 | B5, B39 | B5, '0);
        bus_write(8'h1C, 32'h0000_0005);
        chk_read(8'h18, 32'h8027_003F, "R5 slot without on bit");
        bus_write(8'h20, 32'h8000_0028);
        chk_read(8'h20, 32'h8000_0028, "R2 slot1 id 40 stored");
        set_src(ALL, ALL, '0);
        chk_read(8'h18, 32'h8027_003F, "R5 id 40 ignored");
        bus_write(8'h28, 32'h8000_0007);
        bus_write(8'h2C, 32'h8000_0006);
        set_src(ALL, ALL, B7 | B6);
        chk_read(8'h18, 32'h8027_8007, "R6 slot order not id order");
        set_src('0, ALL, B7 | B6);
        chk_read(8'h18, 32'h003F_003F, "R9 nothing pending");

        wait (sb.size() == 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule